// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block executes one element-wise vector command at a time against a small internal vector register file, under the control of a per-element mask register. Test commands compare the elements of one or two source vectors and build the mask from the results. Mask commands invert the mask or set every bit of it. Arithmetic commands (add, multiply, copy) then walk the vector and write the destination only where the mask allows. This makes an if/else selection two masked copies with a mask inversion between them.

Arithmetic commands have two sequencing modes. In the simple mode every element slot below the vector length takes one cycle, and the mask only gates the write. In the density-time mode the sequencer jumps from one set mask bit to the next, so the run time follows the number of active elements instead of the vector length. Vector elements are loaded and read through element-wide side ports, which makes the block easy to drive from a scalar host.

Top module: `vmask_seq`

## Requirements
- R1: After reset, busy and done are 0, mask_out is all ones and every element of every register reads 0.
- R2: Arithmetic commands use cmd_op 0 (add, result modulo 2^W), 1 (multiply, low W bits of the product) and 2 (copy source A). Element i of the destination takes the result when i is below the effective length and mask bit i is 1.
- R3: A destination element whose mask bit is 0, or whose index is at or above the effective length, keeps its old value; arithmetic commands leave the mask unchanged.
- R4: Test commands write the mask in one busy cycle: cmd_op 3 sets bit i when A[i] is 0, cmd_op 4 when A[i] is non-zero, cmd_op 5 when A[i] >= B[i] (unsigned). Bits at or above the effective length are cleared.
- R5: cmd_op 6 inverts all mask bits and cmd_op 7 sets all mask bits, each in one busy cycle, regardless of length.
- R6: The effective length is cmd_len clamped to the element count. In the simple mode (cmd_dense 0) an arithmetic command keeps busy high for max(length, 1) cycles.
- R7: In the density-time mode (cmd_dense 1) an arithmetic command keeps busy high for max(k, 1) cycles, where k counts the set mask bits below the effective length, and produces the same register contents as the simple mode.
- R8: A command is taken when cmd_valid is high and busy is low; busy rises on the next cycle, and a command offered while busy is ignored. done is high for exactly one cycle, the cycle right after busy falls.
- R9: The load port writes one element when busy is low; a load offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | RW | Register written by the load port |
| ld_idx | input | IW | Element written by the load port |
| ld_data | input | W | Load data |
| cmd_valid | input | 1 | Command offer |
| cmd_op | input | 3 | Command code (see R2, R4, R5) |
| cmd_dense | input | 1 | 1 selects density-time sequencing |
| cmd_dst | input | RW | Destination register |
| cmd_srca | input | RW | Source register A |
| cmd_srcb | input | RW | Source register B |
| cmd_len | input | LW | Vector length |
| rd_reg | input | RW | Register read by the peek port |
| rd_idx | input | IW | Element read by the peek port |
| rd_data | output | W | Peeked element (combinational) |
| mask_out | output | NELEM | Current mask register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a density-time run whose mask has set bits both below and above the vector length, and sparse gaps, because the mask can only be shaped through test commands on vector data. The bench therefore loads a scratch register with zeros exactly where the wanted mask bits are and issues an equal-to-zero test over the full length. This gives it arbitrary masks, which it then combines with every length from 0 past the clamp, both modes and all three arithmetic codes.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

    typedef enum logic [2:0] {
        VOP_ADD  = 3'd0,
        VOP_MUL  = 3'd1,
        VOP_MOV  = 3'd2,
        VOP_TEQZ = 3'd3,
        VOP_TNEZ = 3'd4,
        VOP_TGE  = 3'd5,
        VOP_MNOT = 3'd6,
        VOP_MSET = 3'd7
    } vop_e;

    function automatic logic is_elem_op(input vop_e op);
        return (op == VOP_ADD) || (op == VOP_MUL) || (op == VOP_MOV);
    endfunction

endpackage

// File: rtl/vmask_regfile.sv
module vmask_regfile #(
    parameter int NREGS = 4,
    parameter int NELEM = 8,
    parameter int W     = 8,
    localparam int RW   = $clog2(NREGS),
    localparam int IW   = $clog2(NELEM)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [RW-1:0]            wreg,
    input  logic [IW-1:0]            widx,
    input  logic [W-1:0]             wdata,
    input  logic [RW-1:0]            ra_reg,
    output logic [NELEM-1:0][W-1:0]  ra_vec,
    input  logic [RW-1:0]            rb_reg,
    output logic [NELEM-1:0][W-1:0]  rb_vec,
    input  logic [RW-1:0]            rc_reg,
    input  logic [IW-1:0]            rc_idx,
    output logic [W-1:0]             rc_data
);
    logic [NREGS-1:0][NELEM-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[wreg][widx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign ra_vec  = mem_q[ra_reg];
    assign rb_vec  = mem_q[rb_reg];
    assign rc_data = mem_q[rc_reg][rc_idx];
endmodule

// File: rtl/vmask_alu.sv
module vmask_alu
    import vmask_pkg::*;
#(
    parameter int W = 8
) (
    input  vop_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = a * b;
        case (op)
            VOP_ADD: y = a + b;
            VOP_MUL: y = prod[W-1:0];
            default: y = a;
        endcase
    end
endmodule

// File: rtl/vmask_scan.sv
module vmask_scan #(
    parameter int N    = 8,
    localparam int IW  = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [IW:0]   from,
    output logic          found,
    output logic [IW-1:0] pos
);
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i] && (i >= int'(from))) begin
                found = 1'b1;
                pos   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vmask_seq.sv
module vmask_seq
    import vmask_pkg::*;
#(
    parameter int NREGS = 4,
    parameter int NELEM = 8,
    parameter int W     = 8,
    localparam int RW   = $clog2(NREGS),
    localparam int IW   = $clog2(NELEM),
    localparam int LW   = $clog2(NELEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [RW-1:0]    ld_reg,
    input  logic [IW-1:0]    ld_idx,
    input  logic [W-1:0]     ld_data,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_dense,
    input  logic [RW-1:0]    cmd_dst,
    input  logic [RW-1:0]    cmd_srca,
    input  logic [RW-1:0]    cmd_srcb,
    input  logic [LW-1:0]    cmd_len,
    input  logic [RW-1:0]    rd_reg,
    input  logic [IW-1:0]    rd_idx,
    output logic [W-1:0]     rd_data,
    output logic [NELEM-1:0] mask_out,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic             dense;
        logic             empty;
        vop_e             op;
        logic [RW-1:0]    dst;
        logic [RW-1:0]    sa;
        logic [RW-1:0]    sb;
        logic [LW-1:0]    len;
        logic [IW-1:0]    idx;
        logic [NELEM-1:0] mask;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [LW-1:0]            len_clamp;
    logic [NELEM-1:0]         below_cmd, below_q;
    logic [NELEM-1:0]         hit_eqz, hit_nez, hit_ge;
    logic [NELEM-1:0][W-1:0]  vec_a, vec_b;
    logic [W-1:0]             el_y;
    logic                     first_found, next_found;
    logic [IW-1:0]            first_pos, next_pos;
    logic                     q_elem, seq_we, finish;
    logic                     rf_we;
    logic [RW-1:0]            rf_wreg;
    logic [IW-1:0]            rf_widx;
    logic [W-1:0]             rf_wdata;

    assign len_clamp = (cmd_len > LW'(NELEM)) ? LW'(NELEM) : cmd_len;

    generate
        for (genvar g = 0; g < NELEM; g++) begin : g_lane
            assign below_cmd[g] = LW'(g) < len_clamp;
            assign below_q[g]   = LW'(g) < st_q.len;
            assign hit_eqz[g]   = below_q[g] && (vec_a[g] == '0);
            assign hit_nez[g]   = below_q[g] && (vec_a[g] != '0);
            assign hit_ge[g]    = below_q[g] && (vec_a[g] >= vec_b[g]);
        end
    endgenerate

    vmask_regfile #(.NREGS(NREGS), .NELEM(NELEM), .W(W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .wreg(rf_wreg), .widx(rf_widx), .wdata(rf_wdata),
        .ra_reg(st_q.sa), .ra_vec(vec_a),
        .rb_reg(st_q.sb), .rb_vec(vec_b),
        .rc_reg(rd_reg), .rc_idx(rd_idx), .rc_data(rd_data)
    );

    vmask_alu #(.W(W)) u_alu (
        .op(st_q.op), .a(vec_a[st_q.idx]), .b(vec_b[st_q.idx]), .y(el_y)
    );

    vmask_scan #(.N(NELEM)) u_scan_first (
        .vec(st_q.mask & below_cmd), .from('0),
        .found(first_found), .pos(first_pos)
    );

    vmask_scan #(.N(NELEM)) u_scan_next (
        .vec(st_q.mask & below_q), .from((IW+1)'(st_q.idx) + 1'b1),
        .found(next_found), .pos(next_pos)
    );

    assign q_elem = is_elem_op(st_q.op);
    assign seq_we = st_q.busy && q_elem && !st_q.empty &&
                    st_q.mask[st_q.idx] && (LW'(st_q.idx) < st_q.len);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        finish    = 1'b0;
        if (!st_q.busy) begin
            if (cmd_valid) begin
                st_d.busy  = 1'b1;
                st_d.op    = vop_e'(cmd_op);
                st_d.dense = cmd_dense;
                st_d.dst   = cmd_dst;
                st_d.sa    = cmd_srca;
                st_d.sb    = cmd_srcb;
                st_d.len   = len_clamp;
                st_d.idx   = '0;
                st_d.empty = 1'b0;
                if (is_elem_op(vop_e'(cmd_op))) begin
                    if (cmd_dense) begin
                        st_d.empty = !first_found;
                        st_d.idx   = first_found ? first_pos : '0;
                    end else begin
                        st_d.empty = (len_clamp == '0);
                    end
                end
            end
        end else if (!q_elem) begin
            case (st_q.op)
                VOP_TEQZ: st_d.mask = hit_eqz;
                VOP_TNEZ: st_d.mask = hit_nez;
                VOP_TGE:  st_d.mask = hit_ge;
                VOP_MNOT: st_d.mask = ~st_q.mask;
                default:  st_d.mask = '1;
            endcase
            finish = 1'b1;
        end else if (st_q.dense) begin
            if (!st_q.empty && next_found) st_d.idx = next_pos;
            else                           finish   = 1'b1;
        end else begin
            if (((LW+1)'(st_q.idx) + 1'b1) < (LW+1)'(st_q.len))
                st_d.idx = st_q.idx + 1'b1;
            else
                finish = 1'b1;
        end
        if (finish) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_we    = seq_we || (!st_q.busy && ld_en);
    assign rf_wreg  = st_q.busy ? st_q.dst : ld_reg;
    assign rf_widx  = st_q.busy ? st_q.idx : ld_idx;
    assign rf_wdata = st_q.busy ? el_y     : ld_data;

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign mask_out = st_q.mask;

    // R8: completion strobe lasts one cycle and never overlaps a run
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: density-time sequencing only visits active elements, ascending
    a_r7_dense_hits_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.dense && q_elem && !st_q.empty) |->
            (mask_out[st_q.idx] && (LW'(st_q.idx) < st_q.len)));
    a_r7_dense_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.dense && q_elem) ##1 busy |-> (st_q.idx > $past(st_q.idx)));
    // R6: simple mode steps by exactly one slot per cycle
    a_r6_simple_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !st_q.dense && q_elem) ##1 busy |-> (st_q.idx == IW'($past(st_q.idx) + 1'b1)));
    // R3: arithmetic commands never disturb the mask
    a_r3_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q_elem) |=> $stable(mask_out));
    // R4 / R5: mask commands occupy a single busy cycle
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q_elem) |=> !busy);
endmodule

// File: tb/vmask_seq_test.sv
module vmask_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_en = 1'b0;
    logic [1:0] ld_reg = '0;
    logic [2:0] ld_idx = '0;
    logic [7:0] ld_data = '0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic       cmd_dense = 1'b0;
    logic [1:0] cmd_dst = '0, cmd_srca = '0, cmd_srcb = '0;
    logic [3:0] cmd_len = '0;
    logic [1:0] rd_reg = '0;
    logic [2:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic [7:0] mask_out;
    logic       busy, done;

    int total = 0;
    int bad = 0;
    logic [7:0] model [4][8];
    logic [7:0] mexp;

    vmask_seq uut (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dense(cmd_dense),
        .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb), .cmd_len(cmd_len),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
        .mask_out(mask_out), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int r, input int i, input logic [7:0] v);
        ld_en = 1'b1; ld_reg = 2'(r); ld_idx = 3'(i); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        model[r][i] = v;
    endtask

    task automatic peek(input int r, input int i, output logic [7:0] v);
        rd_reg = 2'(r); rd_idx = 3'(i);
        #0.5;
        v = rd_data;
    endtask

    task automatic issue(input int op, input bit dn, input int d, input int a,
                         input int b, input int len, output int cyc);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_dense = dn;
        cmd_dst = 2'(d); cmd_srca = 2'(a); cmd_srcb = 2'(b); cmd_len = 4'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        chk(done === 1'b1, "R8 done after busy", int'(done), 1);
        @(negedge clk);
        chk(done === 1'b0, "R8 done single pulse", int'(done), 0);
    endtask

    function automatic logic [7:0] f_res(input int op, input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = a * b;
        if (op == 0) return a + b;
        if (op == 1) return p[7:0];
        return a;
    endfunction

    // shape the mask through an equal-to-zero test on register 3 (R4)
    task automatic set_mask(input logic [7:0] m);
        int cyc;
        for (int i = 0; i < 8; i++) load(3, i, m[i] ? 8'd0 : 8'(i + 1));
        issue(3, 1'b0, 0, 3, 3, 8, cyc);
        chk(mask_out === m, "R4 mask via equal-zero test", int'(mask_out), int'(m));
        mexp = m;
    endtask

    initial begin
        logic [7:0] v, mm, pats [6];
        int cyc, lens [10];
        logic [7:0] lcg;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(done === 1'b0, "R1 done after reset", int'(done), 0);
        chk(mask_out === 8'hFF, "R1 mask after reset", int'(mask_out), 8'hFF);
        for (int r = 0; r < 4; r++)
            for (int i = 0; i < 8; i++) begin
                peek(r, i, v);
                chk(v === 8'h00, "R1 register cleared", int'(v), 0);
            end

        lcg = 8'h3C;
        pats = '{8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h81, 8'h00};
        lens = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 12};
        for (int p = 0; p < 6; p++) begin
            lcg = lcg * 8'd37 + 8'd11;
            if (p == 5) pats[5] = lcg;
            for (int i = 0; i < 8; i++) begin
                load(0, i, (i == p) ? 8'd0 : 8'((p * 29 + i * 53 + 7) & 255));
                load(1, i, (i == (p + 3) % 8) ? model[0][i] : 8'((p * 71 + i * 13 + 200) & 255));
            end
            set_mask(pats[p]);
            for (int li = 0; li < 10; li++)
                for (int dn = 0; dn < 2; dn++)
                    for (int op = 0; op < 3; op++) begin
                        int el, k, ecyc;
                        logic [7:0] exp;
                        el = (lens[li] > 8) ? 8 : lens[li];
                        for (int i = 0; i < 8; i++) load(2, i, ~8'(i * 17 + p + op));
                        issue(op, dn[0], 2, 0, 1, lens[li], cyc);
                        k = 0;
                        for (int i = 0; i < el; i++) if (mexp[i]) k++;
                        if (dn == 0) ecyc = (el == 0) ? 1 : el;   // R6
                        else         ecyc = (k == 0) ? 1 : k;     // R7
                        chk(cyc == ecyc, dn ? "R7 dense busy cycles" : "R6 simple busy cycles", cyc, ecyc);
                        chk(mask_out === mexp, "R3 mask unchanged by arithmetic", int'(mask_out), int'(mexp));
                        for (int i = 0; i < 8; i++) begin
                            if (i < el && mexp[i]) exp = f_res(op, model[0][i], model[1][i]);
                            else                   exp = model[2][i];
                            peek(2, i, v);
                            chk(v === exp, (i < el && mexp[i]) ? "R2 masked write" : "R3 element kept",
                                int'(v), int'(exp));
                            model[2][i] = v;
                        end
                    end
            // R4: test commands at several lengths
            for (int op = 3; op < 6; op++)
                for (int li = 0; li < 4; li++) begin
                    int ln, el;
                    ln = (li == 0) ? 0 : (li == 1) ? 3 : (li == 2) ? 8 : 12;
                    el = (ln > 8) ? 8 : ln;
                    issue(op, 1'b0, 0, 0, 1, ln, cyc);
                    mm = '0;
                    for (int i = 0; i < el; i++) begin
                        if (op == 3) mm[i] = (model[0][i] == 0);
                        if (op == 4) mm[i] = (model[0][i] != 0);
                        if (op == 5) mm[i] = (model[0][i] >= model[1][i]);
                    end
                    chk(cyc == 1, "R4 test one cycle", cyc, 1);
                    chk(mask_out === mm, "R4 test result", int'(mask_out), int'(mm));
                end
            // R5: invert then set all
            mm = mask_out;
            issue(6, 1'b1, 0, 0, 0, 2, cyc);
            chk(mask_out === ~mm, "R5 invert", int'(mask_out), int'(~mm));
            chk(cyc == 1, "R5 invert one cycle", cyc, 1);
            issue(7, 1'b0, 0, 0, 0, 0, cyc);
            chk(mask_out === 8'hFF, "R5 set all", int'(mask_out), 8'hFF);
        end

        // R8 / R9: command and load offered while busy are ignored
        set_mask(8'h0F);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_dense = 1'b0;
        cmd_dst = 2'd2; cmd_srca = 2'd0; cmd_srcb = 2'd1; cmd_len = 4'd8;
        @(negedge clk);
        chk(busy === 1'b1, "R8 busy rises after accept", int'(busy), 1);
        cmd_op = 3'd7;
        ld_en = 1'b1; ld_reg = 2'd1; ld_idx = 3'd5; ld_data = ~model[1][5];
        @(negedge clk);
        ld_en = 1'b0; cmd_valid = 1'b0;
        cyc = 0;
        while (busy && cyc < 100) begin cyc++; @(negedge clk); end
        chk(mask_out === 8'h0F, "R8 command during busy ignored", int'(mask_out), 8'h0F);
        peek(1, 5, v);
        chk(v === model[1][5], "R9 load during busy ignored", int'(v), int'(model[1][5]));
        @(negedge clk);
        load(1, 5, 8'h5E);
        peek(1, 5, v);
        chk(v === 8'h5E, "R9 load while idle", int'(v), 8'h5E);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule